// File: doc/BRIEF.md
# Pipeline Hazard Controller (load-use bubble and branch squash)

This block is the hazard control for a five-stage in-order pipeline that fetches past every branch as if the branch were not taken. It watches two things. The first is a load in the execute stage whose destination register is a source of the instruction being decoded. In that case it freezes the program counter and the fetch/decode latch for one cycle. It also clears the control fields that enter the decode/execute latch, so that one empty slot goes down the pipe while the forwarding path from the memory/writeback latch covers the rest.

The second is an equal-compare branch in the execute stage whose ALU zero flag is set. Such a branch was mispredicted. The block steers the program counter to the branch target and squashes the two younger instructions. The one in decode has its control fields cleared. The one being fetched reaches the fetch/decode latch as the all-zero nop word. Target arithmetic lives outside the block.

All outputs are combinational functions of the current inputs and take effect at the next clock edge of the surrounding pipeline. Every pin is a plain control or status wire. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When `ex_mem_read`=1, `ex_dst_reg`≠0 and `ex_dst_reg` equals `dec_src_a` or `dec_src_b`, and no taken branch is present, then `pc_load_en`=0, `fetch_latch_en`=0, `issue_ctrl_clear`=1, `fetch_squash`=0, `pc_src_sel`=0, and `fetch_instr_out` equals `fetch_instr_in`.
- R2: A matching destination of register 0 never produces a stall.
- R3: With `ex_mem_read`=0, register matches never produce a stall.
- R4: A taken branch is `ex_is_beq`=1 with `alu_zero`=1. It drives `pc_src_sel`=1 (target), `pc_load_en`=1, `fetch_latch_en`=1, `fetch_squash`=1 and `issue_ctrl_clear`=1.
- R5: While `fetch_squash`=1, `fetch_instr_out` is the nop word 32'h00000000. Otherwise it equals `fetch_instr_in`.
- R6: A branch with `alu_zero`=0 has no effect on any output, because the not-taken prediction was correct.
- R7: When a taken branch and a load-use match occur together, the branch wins. The outputs are exactly those of R4 and R5, with the PC and the latch written.
- R8: With no hazard, `pc_load_en`=1, `fetch_latch_en`=1, `issue_ctrl_clear`=0, `fetch_squash`=0 and `pc_src_sel`=0 (sequential), and the instruction passes through unchanged.
- R9: The outputs follow the inputs within the same cycle, with no register inside the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_mem_read | input | 1 | Memory-read flag of the instruction in the execute stage |
| ex_dst_reg | input | 5 | Load destination register of the instruction in the execute stage |
| dec_src_a | input | 5 | First source register of the instruction in decode |
| dec_src_b | input | 5 | Second source register of the instruction in decode |
| ex_is_beq | input | 1 | The instruction in the execute stage is an equal-compare branch |
| alu_zero | input | 1 | ALU zero flag for the instruction in the execute stage |
| fetch_instr_in | input | 32 | Instruction word read by fetch this cycle |
| pc_load_en | output | 1 | Write enable of the program counter |
| fetch_latch_en | output | 1 | Write enable of the fetch/decode latch |
| issue_ctrl_clear | output | 1 | Clear the control fields entering the decode/execute latch |
| fetch_squash | output | 1 | Replace the fetched instruction with the nop word |
| pc_src_sel | output | 1 | Next-PC source: 0 sequential, 1 branch target |
| fetch_instr_out | output | 32 | Instruction word to load into the fetch/decode latch |

## Verification
The assertions are immediate checks beside the output logic. They assume that every input carries a settled two-state value whenever the combinational logic is evaluated, and that no X reaches the register-number or flag inputs. The bench keeps to this in two ways. It drives every input from a task on the falling edge, and it samples two nanoseconds later. Its random register numbers are drawn from a small range, so that matches, register-0 matches and branch/stall collisions occur often, next to directed vectors for each corner.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  typedef enum logic {
    PC_SEQ    = 1'b0,
    PC_TARGET = 1'b1
  } pc_src_e;

  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned INSTR_W   = 32;
endpackage

// File: rtl/hzc_load_use_detect.sv
module hzc_load_use_detect #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             ld_pending,
  input  logic [IDX_W-1:0] ld_dst,
  input  logic [IDX_W-1:0] use_a,
  input  logic [IDX_W-1:0] use_b,
  output logic             hazard
);
  localparam int unsigned NUM_SRC = 2;

  logic [NUM_SRC-1:0][IDX_W-1:0] srcs;
  logic [NUM_SRC-1:0]            hit;
  logic                          dst_live;

  assign srcs[0]  = use_a;
  assign srcs[1]  = use_b;
  // Register 0 is hard-wired, so a load into it creates no dependency.
  assign dst_live = |ld_dst;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign hit[g] = (srcs[g] == ld_dst);
  end

  assign hazard = ld_pending & dst_live & (|hit);
endmodule

// File: rtl/hzc_branch_resolve.sv
module hzc_branch_resolve (
  input  logic is_beq,
  input  logic zero_flag,
  output logic redirect
);
  // Fetch assumed fall-through; an equal-compare with zero set disproves it.
  assign redirect = is_beq & zero_flag;
endmodule

// File: rtl/hzc_fetch_nop_mux.sv
module hzc_fetch_nop_mux #(
  parameter int unsigned           W        = 32,
  parameter logic [W-1:0]          NOP_WORD = '0
) (
  input  logic         squash,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] word_out
);
  assign word_out = squash ? NOP_WORD : word_in;
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hzc_pkg::*;
#(
  parameter int unsigned IDX_W = REG_IDX_W,
  parameter int unsigned IW    = INSTR_W
) (
  input  logic          ex_mem_read,
  input  logic [IDX_W-1:0] ex_dst_reg,
  input  logic [IDX_W-1:0] dec_src_a,
  input  logic [IDX_W-1:0] dec_src_b,
  input  logic          ex_is_beq,
  input  logic          alu_zero,
  input  logic [IW-1:0] fetch_instr_in,
  output logic          pc_load_en,
  output logic          fetch_latch_en,
  output logic          issue_ctrl_clear,
  output logic          fetch_squash,
  output logic          pc_src_sel,
  output logic [IW-1:0] fetch_instr_out
);
  localparam logic [IW-1:0] NOP = '0;

  logic    load_use;
  logic    redirect;
  logic    freeze;
  pc_src_e pc_src;

  hzc_load_use_detect #(.IDX_W(IDX_W)) u_lu (
    .ld_pending (ex_mem_read),
    .ld_dst     (ex_dst_reg),
    .use_a      (dec_src_a),
    .use_b      (dec_src_b),
    .hazard     (load_use)
  );

  hzc_branch_resolve u_br (
    .is_beq    (ex_is_beq),
    .zero_flag (alu_zero),
    .redirect  (redirect)
  );

  hzc_fetch_nop_mux #(.W(IW), .NOP_WORD(NOP)) u_nop (
    .squash   (redirect),
    .word_in  (fetch_instr_in),
    .word_out (fetch_instr_out)
  );

  // Redirect outranks the load bubble: the dependent instruction is wrong-path.
  assign freeze           = load_use & ~redirect;
  assign pc_load_en       = ~freeze;
  assign fetch_latch_en   = ~freeze;
  assign issue_ctrl_clear = load_use | redirect;
  assign fetch_squash     = redirect;
  assign pc_src           = redirect ? PC_TARGET : PC_SEQ;
  assign pc_src_sel       = pc_src;

  always_comb begin
    // R4: selecting the target is useless unless PC and latch both take it
    p_target_loads_pc_r4: assert (pc_src_sel == PC_SEQ || (pc_load_en && fetch_latch_en))
      else $error("target selected without PC/latch write");
    // R1: PC and fetch latch freeze together, and a freeze always emits a bubble
    p_lockstep_freeze_r1: assert (pc_load_en == fetch_latch_en && (pc_load_en || issue_ctrl_clear))
      else $error("freeze inconsistent");
    // R5: squashed fetch delivers the nop word
    p_squash_nop_r5: assert (!fetch_squash || fetch_instr_out == NOP)
      else $error("squash without nop");
    // R2: register 0 destination never freezes
    p_zero_reg_r2: assert (ex_dst_reg != '0 || pc_load_en)
      else $error("stall on register 0");
    // R3: no load in EX never freezes
    p_no_load_r3: assert (ex_mem_read || pc_load_en)
      else $error("stall without load");
    // R7: a freeze never coexists with a squash
    p_flush_wins_r7: assert (!(fetch_squash && !pc_load_en))
      else $error("squash while frozen");
  end
endmodule

// File: tb/tb_pipe_hazard_ctrl.sv
module tb_pipe_hazard_ctrl;
  logic        clk = 1'b0;
  logic        ex_mem_read, ex_is_beq, alu_zero;
  logic [4:0]  ex_dst_reg, dec_src_a, dec_src_b;
  logic [31:0] fetch_instr_in, fetch_instr_out;
  logic        pc_load_en, fetch_latch_en, issue_ctrl_clear, fetch_squash, pc_src_sel;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  pipe_hazard_ctrl dut (
    .ex_mem_read(ex_mem_read), .ex_dst_reg(ex_dst_reg),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .ex_is_beq(ex_is_beq), .alu_zero(alu_zero),
    .fetch_instr_in(fetch_instr_in),
    .pc_load_en(pc_load_en), .fetch_latch_en(fetch_latch_en),
    .issue_ctrl_clear(issue_ctrl_clear), .fetch_squash(fetch_squash),
    .pc_src_sel(pc_src_sel), .fetch_instr_out(fetch_instr_out)
  );

  // Expected {pc_load, latch, clear, squash, sel, instr} from the requirements
  function automatic logic [36:0] model(input logic mr, input logic [4:0] d, a, b,
                                        input logic beq, z, input logic [31:0] ins);
    logic lu = mr && d != 5'd0 && (d == a || d == b);
    logic tk = beq && z;
    if (tk)      return {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0};
    else if (lu) return {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, ins};
    else         return {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, ins};
  endfunction

  function automatic string tag(input logic mr, input logic [4:0] d, a, b, input logic beq, z);
    logic m = (d == a || d == b);
    if (beq && z && mr && d != 0 && m) return "R7";
    if (beq && z)                      return "R4,R5";
    if (mr && d != 0 && m)             return beq ? "R1,R6" : "R1";
    if (mr && d == 0 && m)             return "R2";
    if (!mr && m)                      return "R3";
    if (beq)                           return "R6";
    return "R8";
  endfunction

  task automatic apply(input logic mr, input logic [4:0] d, a, b,
                       input logic beq, z, input logic [31:0] ins);
    logic [36:0] exp, got;
    @(negedge clk);
    ex_mem_read = mr; ex_dst_reg = d; dec_src_a = a; dec_src_b = b;
    ex_is_beq = beq; alu_zero = z; fetch_instr_in = ins;
    #2; // R9: combinational, response visible in the same cycle
    exp = model(mr, d, a, b, beq, z, ins);
    got = {pc_load_en, fetch_latch_en, issue_ctrl_clear, fetch_squash, pc_src_sel, fetch_instr_out};
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (mr=%0b d=%0d a=%0d b=%0d beq=%0b z=%0b)",
               tag(mr, d, a, b, beq, z), got, exp, mr, d, a, b, beq, z);
    end
  endtask

  initial begin
    void'($urandom(32'd2016));
    // Quiet inputs while the pipeline is held in reset: R8 idle state
    ex_mem_read = 0; ex_dst_reg = 0; dec_src_a = 0; dec_src_b = 0;
    ex_is_beq = 0; alu_zero = 0; fetch_instr_in = 32'h0;
    repeat (3) @(posedge clk);
    apply(0, 0, 0, 0, 0, 0, 32'h0);            // R8 reset state
    apply(1, 5'd2, 5'd2, 5'd7, 0, 0, 32'h1234_5678);  // R1 via first source
    apply(1, 5'd9, 5'd4, 5'd9, 0, 0, 32'hDEAD_BEEF);  // R1 via second source
    apply(1, 5'd0, 5'd0, 5'd0, 0, 0, 32'hAAAA_5555);  // R2 register 0
    apply(0, 5'd3, 5'd3, 5'd3, 0, 0, 32'h0F0F_0F0F);  // R3 no load
    apply(0, 5'd1, 5'd2, 5'd3, 1, 1, 32'hFFFF_FFFF);  // R4,R5 taken branch
    apply(0, 5'd1, 5'd2, 5'd3, 1, 0, 32'hCAFE_F00D);  // R6 not taken
    apply(1, 5'd8, 5'd8, 5'd1, 1, 1, 32'h1357_9BDF);  // R7 flush over stall
    apply(1, 5'd8, 5'd8, 5'd1, 1, 0, 32'h2468_ACE0);  // R1 with untaken branch
    apply(1, 5'd31, 5'd30, 5'd29, 0, 0, 32'h7777_0000); // R8 near miss
    apply(0, 5'd0, 5'd0, 5'd0, 0, 1, 32'h8000_0001);  // R6 zero without branch
    for (int i = 0; i < 2000; i++)
      apply($urandom % 2, 5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4),
            $urandom % 2, $urandom % 2, $urandom);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule